// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns one reference clock into the two timing enables a serial channel needs: a one-cycle sample tick at the oversampling rate and a bit tick that marks each bit boundary. The sample period is set by a 16-bit integer divisor, loaded as a high byte and a low byte, and a 4-bit fraction in sixteenths. The effective divisor is therefore `integer + fraction/16`. Oversampling can be set to 16, 8 or 4 sample ticks per bit. With a 24 MHz reference at 16x, an integer of 1 and a fraction of 10 give about 921600 bit/s. An integer of 3 with a fraction of 4 gives about 460800 bit/s, and an integer of 2 with no fraction gives exactly 750000 bit/s.

The fraction is applied by adding one reference cycle to selected sample periods. In every group of sixteen periods, exactly `fraction` periods are lengthened, and they are spread across the group rather than placed together. New settings are captured with a one-cycle write strobe. They are held back until the current sample period ends, so a running period is never cut short. Each change also restarts the fractional phase and the bit-boundary count. An integer divisor of zero stops both ticks. Both outputs are clock enables for logic in the reference clock domain; neither is a derived clock.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the active integer divisor is zero, and both `sample_tick_o` and `bit_tick_o` stay low until a divisor is written.
- R2: With a fraction of 0 and a nonzero integer divisor D, consecutive sample ticks are exactly D reference cycles apart. For example, D = 3 gives 500000 bit/s from 24 MHz at 16x.
- R3: For an integer divisor D and any fraction, every sample period is either D or D+1 reference cycles long.
- R4: Number the sample periods k = 0, 1, 2, … starting from the moment new settings take effect, and let F be the fraction. Period k is D + floor((k+1)·F/16) − floor(k·F/16) cycles long. As a result, the first sixteen periods together last exactly 16·D + F cycles.
- R5: `os_mode_i` selects the oversampling factor N: 2'b00 gives 16, 2'b01 gives 8, and 2'b10 or 2'b11 give 4. Counting sample ticks from the moment new settings take effect, `bit_tick_o` is high together with the N-th tick, the 2N-th tick, and so on.
- R6: A high `div_wr_i` captures `div_hi_i`, `div_lo_i`, `div_frac_i` and `os_mode_i`. While the block is running, the old settings stay in force up to and including the first sample tick after the write cycle. This also holds when a tick falls in the write cycle itself. The new period and bit count start from that first tick.
- R7: While the active integer divisor is 0, both outputs stay low. A write of a nonzero integer D in that state makes the first sample tick appear D clock edges after the edge that samples the write.
- R8: An integer divisor of 1 with a nonzero fraction is legal and gives sample periods of 1 or 2 cycles, as set out in R4.
- R9: `sample_tick_o` is a single-cycle pulse: when the integer divisor is 2 or more, it is never high in two consecutive cycles.
- R10: `bit_tick_o` is never high in a cycle where `sample_tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 1 | One-cycle strobe that captures the new divisor and mode |
| div_hi_i | input | 8 | Upper byte of the integer divisor |
| div_lo_i | input | 8 | Lower byte of the integer divisor |
| div_frac_i | input | 4 | Fractional divisor in sixteenths |
| os_mode_i | input | 2 | Oversampling select (00: 16x, 01: 8x, 1x: 4x) |
| sample_tick_o | output | 1 | One-cycle enable at the oversampling rate |
| bit_tick_o | output | 1 | One-cycle enable at each bit boundary |

## Verification
Two events can fall in the same cycle: a write strobe and the end of a sample period. In the same way, a pending update and a bit boundary can coincide.

The bench provokes the first case with an integer divisor of 1, which ticks in every cycle, so every write lands on a tick. It also writes at random phases. In each case it checks two things:
- the period that ends after the write still has the old length;
- the periods after it follow the new divisor, with the phase and bit count restarted.

Random fractions and modes then confirm each period against the floor formula, the sixteen-period sum and the position of every bit tick.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned BIT_CNT_W = 4;

  typedef enum logic [1:0] {
    OS_16X  = 2'b00,
    OS_8X   = 2'b01,
    OS_4X   = 2'b10,
    OS_4X_B = 2'b11
  } os_mode_e;

  // last index of the bit-boundary counter for a mode (N-1)
  function automatic logic [BIT_CNT_W-1:0] os_last(logic [1:0] m);
    case (os_mode_e'(m))
      OS_16X:  return 4'd15;
      OS_8X:   return 4'd7;
      default: return 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/brg_shadow.sv
module brg_shadow #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  output logic              pending_o,
  output logic [INT_W-1:0]  shd_int_o,
  output logic [FRAC_W-1:0] shd_frac_o,
  output logic [INT_W-1:0]  act_int_o,
  output logic [FRAC_W-1:0] act_frac_o,
  output logic [1:0]        act_mode_o
);
  logic [1:0] shd_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o  <= 1'b0;
      shd_int_o  <= '0;
      shd_frac_o <= '0;
      shd_mode_q <= '0;
    end else begin
      pending_o <= wr_i | (pending_o & ~load_i);
      if (wr_i) begin
        shd_int_o  <= int_i;
        shd_frac_o <= frac_i;
        shd_mode_q <= mode_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_int_o  <= '0;
      act_frac_o <= '0;
      act_mode_o <= '0;
    end else if (load_i) begin
      act_int_o  <= shd_int_o;
      act_frac_o <= shd_frac_o;
      act_mode_o <= shd_mode_q;
    end
  end

  p_wr_sets_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pending_o);
  p_load_clears_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_i) |=> !pending_o);
endmodule

// File: rtl/brg_frac_phase.sv
module brg_frac_phase #(
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              load_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  localparam logic [FRAC_W:0] GRP = (FRAC_W+1)'(1) << FRAC_W;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_base;
  logic [FRAC_W:0]   sum;

  // a new setting restarts the phase from zero
  assign acc_base = load_i ? '0 : acc_q;
  assign sum      = {1'b0, acc_base} + {1'b0, frac_i};
  assign carry_o  = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (reload_i) acc_q <= sum[FRAC_W-1:0];
  end

  // group bookkeeping for the stretch-count property
  logic [FRAC_W:0] win_q;
  logic [FRAC_W:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      st_q  <= '0;
    end else if (load_i) begin
      win_q <= (FRAC_W+1)'(1);
      st_q  <= {{FRAC_W{1'b0}}, carry_o};
    end else if (reload_i && win_q != GRP) begin
      win_q <= win_q + 1'b1;
      st_q  <= st_q + {{FRAC_W{1'b0}}, carry_o};
    end
  end

  p_group_stretch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == GRP && !load_i) |-> st_q == {1'b0, frac_i});
endmodule

// File: rtl/brg_period_cnt.sv
module brg_period_cnt #(
  parameter int unsigned INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [INT_W:0]   len_i,
  input  logic [INT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W:0]   len_m1;

  assign len_m1 = len_i - 1'b1;
  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_m1[INT_W-1:0];
    end else if (en_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= lim_i);
  p_tick_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && len_i > (INT_W+1)'(1)) |=> !tick_o);
endmodule

// File: rtl/brg_bit_cnt.sv
module brg_bit_cnt
  import brg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  output logic       bit_tick_o
);
  logic [BIT_CNT_W-1:0] bit_q;
  logic [BIT_CNT_W-1:0] last;

  assign last       = os_last(mode_i);
  assign bit_tick_o = tick_i && (bit_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bit_q <= '0;
    else if (load_i) bit_q <= '0;
    else if (tick_i) bit_q <= (bit_q == last) ? '0 : bit_q + 1'b1;
  end

  p_bit_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= last);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_wr_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic [1:0]        os_mode_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  localparam int unsigned INT_W = 2 * BYTE_W;

  logic              pending;
  logic [INT_W-1:0]  shd_int, act_int, nxt_int;
  logic [FRAC_W-1:0] shd_frac, act_frac, nxt_frac;
  logic [1:0]        act_mode;
  logic              en, load, reload, carry;
  logic [INT_W:0]    len;

  assign en       = act_int != '0;
  // settings apply at a period boundary, or at once when stopped
  assign load     = pending && (sample_tick_o || !en);
  assign reload   = sample_tick_o || load;
  assign nxt_int  = load ? shd_int  : act_int;
  assign nxt_frac = load ? shd_frac : act_frac;
  assign len      = {1'b0, nxt_int} + {{INT_W{1'b0}}, carry};

  brg_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (div_wr_i),
    .int_i      ({div_hi_i, div_lo_i}),
    .frac_i     (div_frac_i),
    .mode_i     (os_mode_i),
    .load_i     (load),
    .pending_o  (pending),
    .shd_int_o  (shd_int),
    .shd_frac_o (shd_frac),
    .act_int_o  (act_int),
    .act_frac_o (act_frac),
    .act_mode_o (act_mode)
  );

  brg_frac_phase #(.FRAC_W(FRAC_W)) i_frac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .load_i   (load),
    .frac_i   (nxt_frac),
    .carry_o  (carry)
  );

  brg_period_cnt #(.INT_W(INT_W)) i_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .reload_i (reload),
    .len_i    (len),
    .lim_i    (act_int),
    .tick_o   (sample_tick_o)
  );

  brg_bit_cnt i_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .tick_i     (sample_tick_o),
    .mode_i     (act_mode),
    .bit_tick_o (bit_tick_o)
  );

  p_zero_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_int == '0) |-> (!sample_tick_o && !bit_tick_o));
endmodule

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       div_wr = 1'b0;
  logic [7:0] div_hi = '0, div_lo = '0;
  logic [3:0] div_frac = '0;
  logic [1:0] os_mode = '0;
  logic       sample_tick, bit_tick;

  int checks = 0, errors = 0, cyc = 0, last_t = 0, cur_int = 0;
  bit stopped = 1'b1;

  always #2 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk_i(clk), .rst_ni(rst_ni), .div_wr_i(div_wr), .div_hi_i(div_hi),
    .div_lo_i(div_lo), .div_frac_i(div_frac), .os_mode_i(os_mode),
    .sample_tick_o(sample_tick), .bit_tick_o(bit_tick)
  );

  function automatic int stretch(int k, int f);
    return ((k + 1) * f) / 16 - (k * f) / 16;
  endfunction

  function automatic int os_n(int m);
    return (m == 0) ? 16 : (m == 1) ? 8 : 4;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (bit_tick && !sample_tick) chk(1'b0, "R10 bit tick without sample tick", 1, 0);
  endtask

  task automatic run_cfg(int iv, int f, int m, int nper);
    int n = os_n(m);
    int t_prev, tot, to, d, e;
    string lbl;
    div_hi = 8'(iv >> 8); div_lo = 8'(iv); div_frac = 4'(f); os_mode = 2'(m);
    div_wr = 1'b1;
    step();
    div_wr = 1'b0;
    if (stopped) begin
      t_prev = cyc;
    end else begin
      to = 0;
      while (!sample_tick && to < cur_int + 3) begin step(); to++; end
      if (!sample_tick) begin
        chk(1'b0, "R6 no boundary tick after write", 0, 1);
        return;
      end
      chk((cyc - last_t == cur_int) || (cyc - last_t == cur_int + 1),
          "R6 old period kept through write", cyc - last_t, cur_int);
      t_prev = cyc;
    end
    cur_int = iv;
    stopped = (iv == 0);
    if (iv == 0) begin
      repeat (200) begin
        step();
        chk(!sample_tick && !bit_tick, "R7 outputs quiet at zero divisor",
            int'(sample_tick) + int'(bit_tick), 0);
      end
      return;
    end
    tot = 0;
    for (int k = 0; k < nper; k++) begin
      to = 0;
      do begin step(); to++; end while (!sample_tick && to < iv + 2);
      if (!sample_tick) begin
        chk(1'b0, "R3 sample tick missing", 0, 1);
        last_t = cyc;
        return;
      end
      d = cyc - t_prev;
      e = iv + stretch(k, f);
      lbl = (f == 0) ? "R2 integer period" : (iv == 1) ? "R8 divisor one with fraction"
                                                       : "R4 stretched period";
      chk(d == e, lbl, d, e);
      chk(d == iv || d == iv + 1, "R3 period within D..D+1", d, iv);
      if (iv >= 2) chk(d >= 2, "R9 single-cycle tick", d, 2);
      tot += d;
      if (k == 15) chk(tot == 16 * iv + f, "R4 sixteen-period sum", tot, 16 * iv + f);
      chk(bit_tick == (((k + 1) % n) == 0), "R5 bit boundary", int'(bit_tick),
          int'(((k + 1) % n) == 0));
      t_prev = cyc;
    end
    last_t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int iv, f, m, np;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (40) begin
      step();
      chk(!sample_tick && !bit_tick, "R1 quiet after reset",
          int'(sample_tick) + int'(bit_tick), 0);
    end
    run_cfg(5, 0, 0, 20);      // from stop: first tick D edges after write
    run_cfg(3, 0, 0, 32);      // plain integer
    run_cfg(1, 10, 0, 32);     // divisor one with fraction
    run_cfg(3, 4, 0, 32);
    run_cfg(1, 0, 0, 16);      // ticks every cycle
    run_cfg(2, 0, 1, 24);      // write lands on a tick, 8x
    run_cfg(5, 7, 2, 24);      // 4x
    run_cfg(4, 15, 3, 20);     // 4x alternate code, max fraction
    run_cfg(258, 3, 0, 20);    // high byte in use
    run_cfg(0, 0, 0, 0);       // stop
    run_cfg(6, 9, 1, 20);      // restart from stop with fraction
    for (int r = 0; r < 16; r++) begin
      iv = 1 + int'($urandom_range(39));
      f  = int'($urandom_range(15));
      m  = int'($urandom_range(3));
      np = 16 + int'($urandom_range(24));
      run_cfg(iv, f, m, np);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule